// File: doc/BRIEF.md
# Rotating Display Window Address Mapper

This block places a twelve-digit window over two circular memories that sit outside it: a 48-entry memory of character codes and a 12-entry memory of auxiliary symbols. It holds one start pointer for each memory. For a digit index supplied by the scan logic, it returns the read address that digit uses in each memory. It also returns two enable bits, one saying whether the digit shows its character and one saying whether it shows its auxiliary symbol. The same digit index always reads the start pointer plus that index, wrapped at the memory's depth. Moving a start pointer therefore scrolls the whole window.

The block receives three decoded command strobes, each with its own fields. A load command sets both pointers at once. A shift command moves the selected pointers by one place, either left or right. An on/off command loads a per-digit mask, two class-select bits and an all-off bit. A two-state gate machine remembers whether the display is lit. Its states are GATE_DARK, which is the reset state, and GATE_LIT. The arc GATE_DARK to GATE_LIT is taken on an on/off command whose all-off bit is 0 and that has at least one class bit set. The arc GATE_LIT to GATE_DARK is taken on an on/off command whose all-off bit is 1 or whose class bits are both 0. Any other on/off command leaves the state where it is and only refreshes the mask and the class bits.

Top module: `dispwin_mapper`

## Requirements
- R1: After reset both pointers are 0, and both enables are 0 for every digit index.
- R2: With main pointer P, digit index n (0 to 11) gives main_addr = (P + n) mod 48.
- R3: With auxiliary pointer Q, digit index n (0 to 11) gives aux_addr = (Q + n) mod 12.
- R4: A load command writes both pointers in one step. A main value of 48 or more is stored modulo 48, and an auxiliary value of 12 or more is stored modulo 12.
- R5: A shift with shift_dir = 0 (left) adds one to each selected pointer, and a shift with shift_dir = 1 (right) subtracts one. The main pointer wraps between 47 and 0, and the auxiliary pointer wraps between 11 and 0.
- R6: shift_m selects the main pointer and shift_a selects the auxiliary pointer. Each moves only when its own bit is 1, so a shift with both bits 0 changes nothing.
- R7: While the all-off bit is 0, digit n has main_en = mask[n] AND M and aux_en = mask[n] AND A. Mask bit 0 belongs to digit index 0. When M = A = 0, every digit is blank whatever the mask holds.
- R8: An on/off command with the all-off bit set blanks every digit, whatever the values of M, A and the mask.
- R9: When a load and a shift arrive in the same cycle, the load wins and the shift is dropped.
- R10: A digit index of 12 or more gives both enables 0 and both addresses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_stb | input | 1 | Load-pointer command strobe |
| load_main | input | 6 | Main start pointer value to load |
| load_aux | input | 4 | Auxiliary start pointer value to load |
| shift_stb | input | 1 | Shift command strobe |
| shift_m | input | 1 | Shift selects the main pointer |
| shift_a | input | 1 | Shift selects the auxiliary pointer |
| shift_dir | input | 1 | Shift direction: 0 is left (+1), 1 is right (−1) |
| onoff_stb | input | 1 | On/off command strobe |
| onoff_mask | input | 12 | Per-digit enable mask; bit n belongs to digit index n |
| onoff_m | input | 1 | Main character class enabled |
| onoff_a | input | 1 | Auxiliary symbol class enabled |
| onoff_alloff | input | 1 | Force every digit blank |
| digit_idx | input | 4 | Digit index being scanned (0 to 11) |
| main_addr | output | 6 | Character memory read address for digit_idx |
| aux_addr | output | 4 | Auxiliary memory read address for digit_idx |
| main_en | output | 1 | Digit shows its character |
| aux_en | output | 1 | Digit shows its auxiliary symbol |

## Verification
The assertions check on every cycle that both addresses stay inside their memories. They also check that each pointer makes the step a command asks for, including the left and right wraps. Finally, they check that a load beats a shift, that all-off leaves every digit dark, and that an out-of-range index gives no enable. What only the bench scenarios can show is the full window: the twelve addresses for a given pointer pair across the wrap boundary. The same holds for the way mask, class bits and all-off combine across a sequence of on/off commands, and for how the pointers and the mask persist from one command to the next.

// File: rtl/dispwin_pkg.sv
package dispwin_pkg;
    localparam int DIGITS     = 12;
    localparam int MAIN_DEPTH = 48;
    localparam int AUX_DEPTH  = 12;

    typedef enum logic {
        GATE_DARK = 1'b0,
        GATE_LIT  = 1'b1
    } gate_state_e;
endpackage

// File: rtl/ring_pointer.sv
module ring_pointer #(
    parameter int MOD = 48,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         dir,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] load_red;
    logic [W-1:0] ptr_nxt;

    always_comb begin
        load_red = W'(32'(load_val) % MOD);
        ptr_nxt  = ptr;
        if (load) begin
            ptr_nxt = load_red;
        end else if (step) begin
            if (!dir) ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
            else      ptr_nxt = (ptr == '0) ? LAST : ptr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < MOD);

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && 32'(load_val) < MOD) |=> (ptr == $past(load_val)));

    // R5
    left_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && !dir && ptr == LAST) |=> (ptr == '0));

    // R5
    right_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && dir && ptr == '0) |=> (ptr == LAST));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(ptr));
endmodule

// File: rtl/window_addr.sv
module window_addr #(
    parameter int MOD    = 48,
    parameter int W      = $clog2(MOD),
    parameter int DIGITS = 12,
    parameter int IW     = 4
) (
    input  logic [W-1:0]  base,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  addr
);
    localparam int SW = ((W > IW) ? W : IW) + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum = SW'(base) + SW'(idx);
        if (32'(idx) >= DIGITS) addr = '0;
        else if (32'(sum) >= MOD) addr = W'(32'(sum) - MOD);
        else addr = W'(sum);
    end
endmodule

// File: rtl/digit_gate.sv
module digit_gate
    import dispwin_pkg::*;
#(
    parameter int NDIG = DIGITS,
    parameter int IW   = $clog2(NDIG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_stb,
    input  logic [NDIG-1:0] cmd_mask,
    input  logic            cmd_m,
    input  logic            cmd_a,
    input  logic            cmd_off,
    input  logic [IW-1:0]   idx,
    output logic            main_en,
    output logic            aux_en
);
    gate_state_e     state, state_nxt;
    logic [NDIG-1:0] mask_q;
    logic            m_q, a_q;
    logic            turn_on;
    logic            digit_ok;

    assign turn_on = !cmd_off && (cmd_m || cmd_a);

    always_comb begin
        state_nxt = state;
        unique case (state)
            GATE_DARK: if (cmd_stb && turn_on)  state_nxt = GATE_LIT;
            GATE_LIT:  if (cmd_stb && !turn_on) state_nxt = GATE_DARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= GATE_DARK;
            mask_q <= '0;
            m_q    <= 1'b0;
            a_q    <= 1'b0;
        end else begin
            state <= state_nxt;
            if (cmd_stb) begin
                mask_q <= cmd_mask;
                m_q    <= cmd_m;
                a_q    <= cmd_a;
            end
        end
    end

    always_comb begin
        digit_ok = (32'(idx) < NDIG) && mask_q[idx];
        main_en  = 1'b0;
        aux_en   = 1'b0;
        unique case (state)
            GATE_DARK: ;
            GATE_LIT: begin
                main_en = digit_ok && m_q;
                aux_en  = digit_ok && a_q;
            end
        endcase
    end

    // R8
    alloff_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_off) |=> (!main_en && !aux_en));

    // R7
    class_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !cmd_m && !cmd_a) |=> (!main_en && !aux_en));

    // R10
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(idx) >= NDIG) |-> (!main_en && !aux_en));
endmodule

// File: rtl/dispwin_mapper.sv
module dispwin_mapper
    import dispwin_pkg::*;
#(
    parameter int NDIG  = DIGITS,
    parameter int MDEP  = MAIN_DEPTH,
    parameter int ADEP  = AUX_DEPTH,
    parameter int MW    = $clog2(MDEP),
    parameter int AW    = $clog2(ADEP),
    parameter int IW    = $clog2(NDIG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_stb,
    input  logic [MW-1:0]   load_main,
    input  logic [AW-1:0]   load_aux,
    input  logic            shift_stb,
    input  logic            shift_m,
    input  logic            shift_a,
    input  logic            shift_dir,
    input  logic            onoff_stb,
    input  logic [NDIG-1:0] onoff_mask,
    input  logic            onoff_m,
    input  logic            onoff_a,
    input  logic            onoff_alloff,
    input  logic [IW-1:0]   digit_idx,
    output logic [MW-1:0]   main_addr,
    output logic [AW-1:0]   aux_addr,
    output logic            main_en,
    output logic            aux_en
);
    logic [MW-1:0] main_ptr;
    logic [AW-1:0] aux_ptr;

    ring_pointer #(.MOD(MDEP), .W(MW)) u_main_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(load_stb), .load_val(load_main),
        .step(shift_stb && shift_m), .dir(shift_dir),
        .ptr(main_ptr)
    );

    ring_pointer #(.MOD(ADEP), .W(AW)) u_aux_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(load_stb), .load_val(load_aux),
        .step(shift_stb && shift_a), .dir(shift_dir),
        .ptr(aux_ptr)
    );

    window_addr #(.MOD(MDEP), .W(MW), .DIGITS(NDIG), .IW(IW)) u_main_win (
        .base(main_ptr), .idx(digit_idx), .addr(main_addr)
    );

    window_addr #(.MOD(ADEP), .W(AW), .DIGITS(NDIG), .IW(IW)) u_aux_win (
        .base(aux_ptr), .idx(digit_idx), .addr(aux_addr)
    );

    digit_gate #(.NDIG(NDIG), .IW(IW)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .cmd_stb(onoff_stb), .cmd_mask(onoff_mask),
        .cmd_m(onoff_m), .cmd_a(onoff_a), .cmd_off(onoff_alloff),
        .idx(digit_idx),
        .main_en(main_en), .aux_en(aux_en)
    );

    // R2
    main_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(main_addr) < MDEP);

    // R3
    aux_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(aux_addr) < ADEP);
endmodule

// File: tb/test_dispwin_mapper.sv
module test_dispwin_mapper;
    typedef struct {
        logic [5:0] ma;
        logic [3:0] aa;
        logic       me;
        logic       ae;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [5:0]  load_main = '0;
    logic [3:0]  load_aux = '0;
    logic        shift_stb = 1'b0, shift_m = 1'b0, shift_a = 1'b0, shift_dir = 1'b0;
    logic        onoff_stb = 1'b0, onoff_m = 1'b0, onoff_a = 1'b0, onoff_alloff = 1'b0;
    logic [11:0] onoff_mask = '0;
    logic [3:0]  digit_idx = '0;
    logic [5:0]  main_addr;
    logic [3:0]  aux_addr;
    logic        main_en, aux_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    // reference state kept from the requirements
    int          mp = 0, ap = 0;
    logic [11:0] m_mask = '0;
    bit          m_m = 0, m_a = 0, m_off = 0;

    always #4 clk = ~clk;

    dispwin_mapper i_dispwin_mapper (
        .clk(clk), .rst_n(rst_n),
        .load_stb(load_stb), .load_main(load_main), .load_aux(load_aux),
        .shift_stb(shift_stb), .shift_m(shift_m), .shift_a(shift_a), .shift_dir(shift_dir),
        .onoff_stb(onoff_stb), .onoff_mask(onoff_mask), .onoff_m(onoff_m),
        .onoff_a(onoff_a), .onoff_alloff(onoff_alloff),
        .digit_idx(digit_idx),
        .main_addr(main_addr), .aux_addr(aux_addr), .main_en(main_en), .aux_en(aux_en)
    );

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_load(input int mv, input int av, input bit with_shift);
        @(negedge clk);
        load_stb = 1'b1; load_main = 6'(mv); load_aux = 4'(av);
        if (with_shift) begin
            shift_stb = 1'b1; shift_m = 1'b1; shift_a = 1'b1; shift_dir = 1'b0;
        end
        @(negedge clk);
        load_stb = 1'b0; shift_stb = 1'b0;
        mp = mv % 48; ap = av % 12;
    endtask

    task automatic do_shift(input bit sm, input bit sa, input bit dir);
        @(negedge clk);
        shift_stb = 1'b1; shift_m = sm; shift_a = sa; shift_dir = dir;
        @(negedge clk);
        shift_stb = 1'b0;
        if (sm) mp = dir ? (mp + 47) % 48 : (mp + 1) % 48;
        if (sa) ap = dir ? (ap + 11) % 12 : (ap + 1) % 12;
    endtask

    task automatic do_onoff(input logic [11:0] mask, input bit m, input bit a, input bit off);
        @(negedge clk);
        onoff_stb = 1'b1; onoff_mask = mask; onoff_m = m; onoff_a = a; onoff_alloff = off;
        @(negedge clk);
        onoff_stb = 1'b0;
        m_mask = mask; m_m = m; m_a = a; m_off = off;
    endtask

    // drive every index 0..15 and push what the requirements predict
    task automatic scan(input string req);
        for (int n = 0; n < 16; n++) begin
            exp_t e;
            @(negedge clk);
            digit_idx = 4'(n);
            if (n < 12) begin
                e.ma = 6'((mp + n) % 48);
                e.aa = 4'((ap + n) % 12);
                e.me = !m_off && m_mask[n] && m_m;
                e.ae = !m_off && m_mask[n] && m_a;
                e.req = req;
            end else begin
                e.ma = '0; e.aa = '0; e.me = 1'b0; e.ae = 1'b0;
                e.req = "R10";
            end
            q.push_back(e);
        end
        @(negedge clk);
        #3;
    endtask

    // monitor: compare the outputs 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (main_addr !== e.ma || aux_addr !== e.aa ||
                    main_en !== e.me || aux_en !== e.ae) begin
                    fails++;
                    $display("FAIL %s idx=%0d got ma=%0d aa=%0d me=%b ae=%b exp ma=%0d aa=%0d me=%b ae=%b",
                             e.req, digit_idx, main_addr, aux_addr, main_en, aux_en,
                             e.ma, e.aa, e.me, e.ae);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        scan("R1");                            // reset state
        do_onoff(12'hFFF, 1, 1, 0);
        scan("R2,R3,R7");                      // identity window
        do_shift(1, 1, 0);
        scan("R5");                            // left by one
        do_shift(1, 1, 1);
        do_shift(1, 1, 1);
        scan("R5");                            // right wrap to 47 / 11
        do_shift(1, 0, 0);
        scan("R6");                            // main only
        do_shift(0, 1, 1);
        scan("R6");                            // aux only
        do_shift(0, 0, 1);
        scan("R6");                            // neither
        do_load(46, 5, 0);
        scan("R4,R2");
        do_load(63, 15, 0);
        scan("R4");                            // reduced to 15 / 3
        do_onoff(12'h0A5, 1, 0, 0);
        scan("R7");
        do_onoff(12'hF0F, 0, 1, 0);
        scan("R7");
        do_onoff(12'hFFF, 0, 0, 0);
        scan("R7");                            // class bits off blanks all
        do_onoff(12'hFFF, 1, 1, 1);
        scan("R8");
        do_onoff(12'h3C3, 1, 1, 0);
        scan("R7");
        do_load(10, 2, 1);
        scan("R9");                            // load beats shift
        do_load(47, 11, 0);
        do_shift(1, 1, 0);
        scan("R5");                            // left wrap to 0 / 0
        done = 1'b1;
        report();
    end
endmodule